// File: doc/BRIEF.md
# PCI Power-State Capability Controller

This block holds the power-management capability of one PCI function: a read-only capabilities word and a writable control/status word. Configuration writes reach it as dword-addressed, byte-enabled transactions. Each byte of the control/status dword is merged through a write mask and a write-one-to-clear mask. The two-bit device power state inside that word is then checked against the states the function supports and against the allowed transition order. A legal request is taken. An illegal one is quietly undone, and the other written bits are kept.

The block also gates BAR decoding. Memory and I/O decode are live only while the command-register enables are set and the function is in D0. A one-cycle remap request tells the address decoders to rebuild their windows when decoding turns on or off because of a power-state change, or when a write lands on a BAR, the expansion ROM base or the command byte. A parameter can remove the capability altogether. The function then always reads as D0 and decode depends on the command enables alone.

Top module: `pm_state_ctrl`

## Requirements
- R1: While rst_n is low and after its release, the control/status dword reads CTRL_INIT with bits [1:0] forced to 0 (D0), pm_state is 0 and no pulse output is high.
- R2: A write to dword CAP_DW+1 updates each enabled byte as (old AND NOT wmask) OR (data AND wmask), then clears the bits set in both data and the W1C mask. Disabled bytes and dword CAP_DW are unchanged.
- R3: A request for D1 (code 1) is rejected unless capabilities bit 9 is set. A request for D2 (code 2) is rejected unless capabilities bit 10 is set.
- R4: From a non-D0 state, a request for a lower-numbered non-D0 state is rejected. A request for a higher state, or for D0 (code 0) from any state, is accepted. D3hot is code 3.
- R5: On a rejected request, bits [1:0] return to their pre-write value and every other bit keeps its merged value.
- R6: A write whose byte enable 0 is clear, or whose merged state equals the current state, performs no check and raises neither transition pulse.
- R7: mem_dec_en equals cmd_mem_en and io_dec_en equals cmd_io_en while pm_state is 0. Both are 0 in any other state.
- R8: An accepted transition between D0 and a non-D0 state raises remap_req for exactly the one cycle after the write edge.
- R9: remap_req is also raised for one cycle after any write with at least one byte enable to dwords 4 to 9 (BARs) or dword 12 (ROM base), or after a write to dword 1 with byte enable 0 (command byte).
- R10: In the cycle after a checked write, exactly one of trans_ok or trans_bad is high, and trans_from/trans_to carry the old and requested states. Both pulses are low after a cycle without a check.
- R11: With CAP_PRESENT = 0, both capability dwords read 0, pm_state stays 0, no transition pulse is raised, and decode follows the command enables.
- R12: Reading dword CAP_DW returns {capabilities word, next pointer, capability ID 0x01}, and reading any dword outside the two capability dwords returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Dword index of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Dword index of the read |
| rd_data | output | 32 | Read data (combinational) |
| cmd_mem_en | input | 1 | Memory-space enable from the command register |
| cmd_io_en | input | 1 | I/O-space enable from the command register |
| mem_dec_en | output | 1 | Memory BAR decode enable |
| io_dec_en | output | 1 | I/O BAR decode enable |
| remap_req | output | 1 | One-cycle request to rebuild BAR windows |
| pm_state | output | 2 | Current power state |
| trans_ok | output | 1 | Pulse: a state change was taken |
| trans_bad | output | 1 | Pulse: a state change was refused |
| trans_from | output | 2 | State before the last checked write |
| trans_to | output | 2 | State requested by the last checked write |

## Verification
All sixteen (from, to) state pairs are swept on three configurations at once: D1-only support, D1 and D2 support, and capability absent. The sweep separates support gating from ordering rules and from the disabled variant. All sixteen byte-enable patterns are combined with all-ones, all-zeros and two alternating data words. These show which bytes are writable, which bits clear on a one, and that a state write rides inside a mixed-byte write. Writes to every dword below the capability, using low and high byte lanes, separate the BAR, ROM and command triggers from neutral addresses. The command enables are toggled in D0 and in sleep states, which shows the power-state gating of decode.

// File: rtl/pm_pkg.sv
// Package: shared power-state type and the transition legality rule.
// Assumes a two-bit state code with D0 = 0 up to D3hot = 3.
package pm_pkg;

    typedef enum logic [1:0] {
        PM_D0    = 2'd0,
        PM_D1    = 2'd1,
        PM_D2    = 2'd2,
        PM_D3HOT = 2'd3
    } pm_state_e;

    // Positions of the support flags inside the capabilities word.
    localparam int PMC_D1_BIT = 9;
    localparam int PMC_D2_BIT = 10;

    // True when moving from 'cur' to 'req' must be refused.
    function automatic logic pm_illegal(pm_state_e cur, pm_state_e req,
                                        logic d1_ok, logic d2_ok);
        logic unsupported;
        logic backwards;
        unsupported = ((req == PM_D1) && !d1_ok) || ((req == PM_D2) && !d2_ok);
        backwards   = (cur != PM_D0) && (req != PM_D0) && (req < cur);
        return unsupported || backwards;
    endfunction

endpackage

// File: rtl/pm_byte_merge.sv
// Module: per-byte merge of write data into a register.
// Each enabled byte takes writable bits from data, then clears bits where
// data and the write-one-to-clear mask are both one. Purely combinational.
module pm_byte_merge #(
    parameter int          BYTES = 4,
    parameter logic [31:0] WMASK = 32'h0000_0103,
    parameter logic [31:0] W1C   = 32'h0000_8000
) (
    input  logic [BYTES*8-1:0] cur_i,
    input  logic [BYTES*8-1:0] data_i,
    input  logic [BYTES-1:0]   be_i,
    output logic [BYTES*8-1:0] merged_o
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        localparam int LO = b * 8;
        logic [7:0] wm;
        logic [7:0] cm;
        logic [7:0] old_b;
        logic [7:0] dat_b;
        assign wm    = WMASK[LO +: 8];
        assign cm    = W1C[LO +: 8];
        assign old_b = cur_i[LO +: 8];
        assign dat_b = data_i[LO +: 8];

        // Combine one lane: masked write, then write-one-to-clear.
        always_comb begin
            if (be_i[b]) begin
                merged_o[LO +: 8] = ((old_b & ~wm) | (dat_b & wm)) & ~(dat_b & cm);
            end else begin
                merged_o[LO +: 8] = old_b;
            end
        end
    end
endmodule

// File: rtl/pm_addr_decode.sv
// Module: classifies a configuration write by dword address and byte lanes.
// Assumes BARs occupy a contiguous dword range, one ROM-base dword, and the
// command byte in lane 0 of its dword.
module pm_addr_decode #(
    parameter int ADDR_W    = 6,
    parameter int CAP_DW    = 16,
    parameter int BAR_FIRST = 4,
    parameter int BAR_COUNT = 6,
    parameter int ROM_DW    = 12,
    parameter int CMD_DW    = 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output logic              hit_ctrl,
    output logic              hit_state,
    output logic              hit_map
);
    localparam int BAR_LAST = BAR_FIRST + BAR_COUNT - 1;
    localparam int CTRL_DW  = CAP_DW + 1;

    logic any_be;
    logic in_bar;
    logic in_rom;
    logic in_cmd;

    // Decode which register groups this write lands on.
    always_comb begin
        any_be    = |be;
        in_bar    = (int'(addr) >= BAR_FIRST) && (int'(addr) <= BAR_LAST) && any_be;
        in_rom    = (int'(addr) == ROM_DW) && any_be;
        in_cmd    = (int'(addr) == CMD_DW) && be[0];
        hit_ctrl  = wr_en && (int'(addr) == CTRL_DW);
        hit_state = hit_ctrl && be[0];
        hit_map   = wr_en && (in_bar || in_rom || in_cmd);
    end
endmodule

// File: rtl/pm_transition_check.sv
// Module: decides whether a requested power state is taken or refused.
// Only evaluates when the state byte was written and the code differs.
module pm_transition_check
    import pm_pkg::*;
(
    input  logic      state_written,
    input  logic [1:0] cur_state,
    input  logic [1:0] req_state,
    input  logic      d1_ok,
    input  logic      d2_ok,
    output logic      checked,
    output logic      accept,
    output logic      reject,
    output logic      d0_boundary
);
    pm_state_e cur_e;
    pm_state_e req_e;

    // Evaluate legality and whether the move crosses the D0 boundary.
    always_comb begin
        cur_e       = pm_state_e'(cur_state);
        req_e       = pm_state_e'(req_state);
        checked     = state_written && (req_e != cur_e);
        reject      = checked && pm_illegal(cur_e, req_e, d1_ok, d2_ok);
        accept      = checked && !reject;
        d0_boundary = (cur_e == PM_D0) != (req_e == PM_D0);
    end
endmodule

// File: rtl/pm_state_ctrl.sv
// Module: power-management capability of one PCI function.
// Holds the capability dwords, applies masked writes, validates power-state
// requests, gates BAR decode by D0 and pulses a remap request. Assumes the
// capability sits at dwords CAP_DW (header + capabilities) and CAP_DW+1.
module pm_state_ctrl #(
    parameter int          ADDR_W      = 6,
    parameter int          CAP_DW      = 16,
    parameter bit          CAP_PRESENT = 1'b1,
    parameter logic [7:0]  NEXT_PTR    = 8'h00,
    parameter logic [15:0] PMC_VALUE   = 16'h0203,
    parameter logic [31:0] CTRL_WMASK  = 32'h0000_0103,
    parameter logic [31:0] CTRL_W1C    = 32'h0000_8000,
    parameter logic [31:0] CTRL_INIT   = 32'h0000_8008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              cmd_mem_en,
    input  logic              cmd_io_en,
    output logic              mem_dec_en,
    output logic              io_dec_en,
    output logic              remap_req,
    output logic [1:0]        pm_state,
    output logic              trans_ok,
    output logic              trans_bad,
    output logic [1:0]        trans_from,
    output logic [1:0]        trans_to
);
    import pm_pkg::*;

    localparam logic [7:0]  CAP_ID     = 8'h01;
    localparam int          CTRL_DW    = CAP_DW + 1;
    localparam logic [31:0] STATE_MASK = 32'h0000_0003;
    localparam logic [31:0] CTRL_RST   = CTRL_INIT & ~STATE_MASK;

    logic        hit_ctrl;
    logic        hit_state;
    logic        hit_map;
    logic [31:0] ctrl_q;
    logic        chk_accept;
    logic        chk_reject;
    logic        d0_cross;
    logic        remap_q;

    pm_addr_decode #(
        .ADDR_W (ADDR_W),
        .CAP_DW (CAP_DW)
    ) u_decode (
        .wr_en     (wr_en),
        .addr      (wr_addr),
        .be        (wr_be),
        .hit_ctrl  (hit_ctrl),
        .hit_state (hit_state),
        .hit_map   (hit_map)
    );

    if (CAP_PRESENT) begin : g_cap
        logic [31:0] merged;
        logic [31:0] ctrl_d;
        logic        checked;
        logic        ok_q;
        logic        bad_q;
        logic [1:0]  from_q;
        logic [1:0]  to_q;

        pm_byte_merge #(
            .BYTES (4),
            .WMASK (CTRL_WMASK),
            .W1C   (CTRL_W1C)
        ) u_merge (
            .cur_i    (ctrl_q),
            .data_i   (wr_data),
            .be_i     (wr_be),
            .merged_o (merged)
        );

        pm_transition_check u_check (
            .state_written (hit_state),
            .cur_state     (ctrl_q[1:0]),
            .req_state     (merged[1:0]),
            .d1_ok         (PMC_VALUE[PMC_D1_BIT]),
            .d2_ok         (PMC_VALUE[PMC_D2_BIT]),
            .checked       (checked),
            .accept        (chk_accept),
            .reject        (chk_reject),
            .d0_boundary   (d0_cross)
        );

        // Pick the stored word: merged value, or merged with the old state.
        always_comb begin
            ctrl_d = merged;
            if (chk_reject) begin
                ctrl_d[1:0] = ctrl_q[1:0];
            end
        end

        // Hold the control/status dword; reset forces the state to D0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q <= CTRL_RST;
            end else if (hit_ctrl) begin
                ctrl_q <= ctrl_d;
            end
        end

        // Register the outcome of a checked write with its endpoints.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ok_q   <= 1'b0;
                bad_q  <= 1'b0;
                from_q <= 2'd0;
                to_q   <= 2'd0;
            end else begin
                ok_q  <= chk_accept;
                bad_q <= chk_reject;
                if (checked) begin
                    from_q <= ctrl_q[1:0];
                    to_q   <= merged[1:0];
                end
            end
        end

        assign trans_ok   = ok_q;
        assign trans_bad  = bad_q;
        assign trans_from = from_q;
        assign trans_to   = to_q;
    end else begin : g_nocap
        logic unused_wr;
        assign unused_wr  = ^{wr_data, hit_state, hit_ctrl, CTRL_WMASK, CTRL_W1C,
                              CTRL_RST, PMC_VALUE};
        assign ctrl_q     = 32'd0;
        assign chk_accept = 1'b0;
        assign chk_reject = 1'b0;
        assign d0_cross   = 1'b0;
        assign trans_ok   = 1'b0;
        assign trans_bad  = 1'b0;
        assign trans_from = 2'd0;
        assign trans_to   = 2'd0;
    end

    // Raise the remap pulse for map-affecting writes and D0 crossings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_q <= 1'b0;
        end else begin
            remap_q <= hit_map || (chk_accept && d0_cross);
        end
    end

    // Return capability dwords; all other addresses read as zero.
    always_comb begin
        rd_data = 32'd0;
        if (CAP_PRESENT && (int'(rd_addr) == CAP_DW)) begin
            rd_data = {PMC_VALUE, NEXT_PTR, CAP_ID};
        end else if (CAP_PRESENT && (int'(rd_addr) == CTRL_DW)) begin
            rd_data = ctrl_q;
        end
    end

    // Gate decode by the command enables and the D0 state.
    always_comb begin
        pm_state   = ctrl_q[1:0];
        mem_dec_en = cmd_mem_en && (pm_state == PM_D0);
        io_dec_en  = cmd_io_en && (pm_state == PM_D0);
    end

    assign remap_req = remap_q;
endmodule

// File: rtl/pm_state_ctrl_chk.sv
// Module: property checker bound to pm_state_ctrl.
// Observes ports only; assumes the synchronous active-low reset.
module pm_state_ctrl_chk #(
    parameter logic [15:0] PMC_VALUE = 16'h0203
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] pm_state,
    input logic       mem_dec_en,
    input logic       io_dec_en,
    input logic       remap_req,
    input logic       trans_ok,
    input logic       trans_bad,
    input logic [1:0] trans_from,
    input logic [1:0] trans_to
);
    p_dec_off_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state != 2'd0) |-> (!mem_dec_en && !io_dec_en));

    p_d1_support_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_ok && trans_to == 2'd1) |-> PMC_VALUE[9]);

    p_d2_support_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_ok && trans_to == 2'd2) |-> PMC_VALUE[10]);

    p_no_backward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trans_ok |-> !((trans_from != 2'd0) && (trans_to != 2'd0) && (trans_to < trans_from)));

    p_taken_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trans_ok |-> (pm_state == trans_to));

    p_refused_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trans_bad |-> (pm_state == trans_from));

    p_still_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pm_state));

    p_remap_cross_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_ok && ((trans_from == 2'd0) != (trans_to == 2'd0))) |-> remap_req);

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(trans_ok && trans_bad));

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!trans_ok && !trans_bad && !remap_req));
endmodule

bind pm_state_ctrl pm_state_ctrl_chk #(
    .PMC_VALUE (PMC_VALUE)
) u_pm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .pm_state   (pm_state),
    .mem_dec_en (mem_dec_en),
    .io_dec_en  (io_dec_en),
    .remap_req  (remap_req),
    .trans_ok   (trans_ok),
    .trans_bad  (trans_bad),
    .trans_from (trans_from),
    .trans_to   (trans_to)
);

// File: tb/pm_state_ctrl_tb_top.sv
// Bench: three configurations driven in parallel (D1 only, D1+D2, absent),
// each followed by an arithmetic model computed from the requirements.
module pm_state_ctrl_tb_top;
    localparam int ADDR_W = 6;
    localparam int CAP_DW = 16;
    localparam logic [31:0] WM   = 32'h0000_0103;
    localparam logic [31:0] W1C  = 32'h0000_8000;
    localparam logic [31:0] INIT = 32'h0000_8008;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [3:0]  wr_be = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic [ADDR_W-1:0] rd_addr = ADDR_W'(CAP_DW + 1);
    logic cmd_mem_en = 1'b1;
    logic cmd_io_en = 1'b1;

    logic [31:0] rdat [3];
    logic        mdec [3];
    logic        idec [3];
    logic        remap [3];
    logic [1:0]  st [3];
    logic        tok [3];
    logic        tbad [3];
    logic [1:0]  tfrom [3];
    logic [1:0]  tto [3];

    logic [15:0] pmc [3];
    logic        cap [3];
    logic [31:0] m_ctrl [3];

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pm_state_ctrl #(.PMC_VALUE(16'h0203)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rdat[0]),
        .cmd_mem_en(cmd_mem_en), .cmd_io_en(cmd_io_en), .mem_dec_en(mdec[0]),
        .io_dec_en(idec[0]), .remap_req(remap[0]), .pm_state(st[0]),
        .trans_ok(tok[0]), .trans_bad(tbad[0]), .trans_from(tfrom[0]), .trans_to(tto[0]));

    pm_state_ctrl #(.PMC_VALUE(16'h0603)) dut_both (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rdat[1]),
        .cmd_mem_en(cmd_mem_en), .cmd_io_en(cmd_io_en), .mem_dec_en(mdec[1]),
        .io_dec_en(idec[1]), .remap_req(remap[1]), .pm_state(st[1]),
        .trans_ok(tok[1]), .trans_bad(tbad[1]), .trans_from(tfrom[1]), .trans_to(tto[1]));

    pm_state_ctrl #(.CAP_PRESENT(1'b0)) dut_none (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rdat[2]),
        .cmd_mem_en(cmd_mem_en), .cmd_io_en(cmd_io_en), .mem_dec_en(mdec[2]),
        .io_dec_en(idec[2]), .remap_req(remap[2]), .pm_state(st[2]),
        .trans_ok(tok[2]), .trans_bad(tbad[2]), .trans_from(tfrom[2]), .trans_to(tto[2]));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_decode(input string req);
        for (int k = 0; k < 3; k++) begin
            check(mdec[k] == (cmd_mem_en && st[k] == 2'd0), req, 32'(mdec[k]),
                  32'(cmd_mem_en && st[k] == 2'd0));
            check(idec[k] == (cmd_io_en && st[k] == 2'd0), req, 32'(idec[k]),
                  32'(cmd_io_en && st[k] == 2'd0));
        end
    endtask

    // R1: reset every device and the model.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        for (int k = 0; k < 3; k++) begin
            m_ctrl[k] = cap[k] ? (INIT & ~32'h3) : 32'd0;
            check(rdat[k] == m_ctrl[k] && st[k] == 2'd0, "R1 reset", rdat[k], m_ctrl[k]);
            check(!tok[k] && !tbad[k] && !remap[k], "R1 pulses", 32'({tok[k], tbad[k], remap[k]}), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write, compared against the model for all three devices.
    task automatic do_write(input int addr, input logic [3:0] be, input logic [31:0] data);
        logic [31:0] nxt [3];
        logic ex_ok [3];
        logic ex_bad [3];
        logic ex_remap [3];
        logic [1:0] oldst [3];
        logic [1:0] reqst [3];
        logic touch_map;
        touch_map = ((addr >= 4 && addr <= 9) && (be != 0)) || (addr == 12 && be != 0)
                    || (addr == 1 && be[0]);
        for (int k = 0; k < 3; k++) begin
            logic [31:0] mg;
            mg = m_ctrl[k];
            ex_ok[k] = 1'b0;
            ex_bad[k] = 1'b0;
            oldst[k] = m_ctrl[k][1:0];
            reqst[k] = oldst[k];
            if (cap[k] && addr == CAP_DW + 1) begin
                for (int b = 0; b < 4; b++) begin
                    if (be[b]) begin
                        mg[b*8 +: 8] = ((m_ctrl[k][b*8 +: 8] & ~WM[b*8 +: 8]) |
                                        (data[b*8 +: 8] & WM[b*8 +: 8])) &
                                       ~(data[b*8 +: 8] & W1C[b*8 +: 8]);
                    end
                end
                reqst[k] = mg[1:0];
                if (be[0] && reqst[k] != oldst[k]) begin
                    ex_bad[k] = (reqst[k] == 2'd1 && !pmc[k][9]) ||
                                (reqst[k] == 2'd2 && !pmc[k][10]) ||
                                (oldst[k] != 0 && reqst[k] != 0 && reqst[k] < oldst[k]);
                    ex_ok[k] = !ex_bad[k];
                end
                if (ex_bad[k]) mg[1:0] = oldst[k];
            end
            nxt[k] = mg;
            ex_remap[k] = touch_map || (ex_ok[k] && ((oldst[k] == 0) != (reqst[k] == 0)));
        end
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_be = be;
        wr_data = data;
        @(posedge clk);
        #1;
        for (int k = 0; k < 3; k++) begin
            m_ctrl[k] = nxt[k];
            check(rdat[k] == nxt[k], "R2/R5 ctrl word", rdat[k], nxt[k]);
            check(st[k] == nxt[k][1:0], "R3/R4/R11 state", 32'(st[k]), 32'(nxt[k][1:0]));
            check(tok[k] == ex_ok[k] && tbad[k] == ex_bad[k], "R6/R10 pulses",
                  32'({tok[k], tbad[k]}), 32'({ex_ok[k], ex_bad[k]}));
            if (ex_ok[k] || ex_bad[k])
                check(tfrom[k] == oldst[k] && tto[k] == reqst[k], "R10 endpoints",
                      32'({tfrom[k], tto[k]}), 32'({oldst[k], reqst[k]}));
            check(remap[k] == ex_remap[k], "R8/R9 remap", 32'(remap[k]), 32'(ex_remap[k]));
        end
        check_decode("R7 decode");
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        for (int k = 0; k < 3; k++)
            check(!remap[k] && !tok[k] && !tbad[k], "R8/R10 single cycle",
                  32'({remap[k], tok[k], tbad[k]}), 0);
    endtask

    initial begin
        pmc[0] = 16'h0203; cap[0] = 1'b1;
        pmc[1] = 16'h0603; cap[1] = 1'b1;
        pmc[2] = 16'h0000; cap[2] = 1'b0;
        do_reset();

        // R12: header dword and an empty dword.
        rd_addr = ADDR_W'(CAP_DW);
        #1;
        for (int k = 0; k < 3; k++) begin
            logic [31:0] e;
            e = cap[k] ? {pmc[k], 8'h00, 8'h01} : 32'd0;
            check(rdat[k] == e, "R12 header", rdat[k], e);
        end
        rd_addr = ADDR_W'(3);
        #1;
        for (int k = 0; k < 3; k++) check(rdat[k] == 32'd0, "R12 empty", rdat[k], 0);
        rd_addr = ADDR_W'(CAP_DW + 1);

        // R3 R4 R5 R8 R10 R11: every from/to pair.
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                do_reset();
                do_write(CAP_DW + 1, 4'b0001, 32'(f));
                do_write(CAP_DW + 1, 4'b0011, 32'h0000_0100 | 32'(t));
            end
        end

        // R6: state byte not enabled, and same-state rewrite.
        do_reset();
        do_write(CAP_DW + 1, 4'b0001, 32'h3);
        do_write(CAP_DW + 1, 4'b1110, 32'h0000_0000);
        do_write(CAP_DW + 1, 4'b0001, 32'h3);

        // R2: merge sweep over all lane patterns and several data words.
        for (int p = 0; p < 4; p++) begin
            logic [31:0] d;
            d = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 : (p == 2) ? 32'hA5A5_A5A5 : 32'h5A5A_5A5A;
            do_reset();
            for (int be = 0; be < 16; be++) do_write(CAP_DW + 1, 4'(be), d);
        end

        // R9: every dword below the capability, low and high lanes; R2 header RO.
        do_reset();
        for (int a = 0; a < CAP_DW; a++) begin
            do_write(a, 4'b0001, 32'hFFFF_FFFF);
            do_write(a, 4'b1100, 32'hFFFF_FFFF);
        end
        do_write(CAP_DW, 4'b1111, 32'hFFFF_FFFF);
        rd_addr = ADDR_W'(CAP_DW);
        #1;
        for (int k = 0; k < 3; k++) begin
            logic [31:0] e;
            e = cap[k] ? {pmc[k], 8'h00, 8'h01} : 32'd0;
            check(rdat[k] == e, "R2 header read-only", rdat[k], e);
        end
        rd_addr = ADDR_W'(CAP_DW + 1);

        // R7: command enables toggled in D0 and in D3hot.
        for (int s = 0; s < 2; s++) begin
            do_reset();
            if (s == 1) do_write(CAP_DW + 1, 4'b0001, 32'h3);
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                cmd_mem_en = c[0];
                cmd_io_en = c[1];
                #1;
                check_decode("R7 command gating");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule